// File: doc/BRIEF.md
# Three-Axis Decimating Block Averager

This block smooths a stream of three-axis sensor readings by replacing each group of three consecutive samples with their per-axis mean. Every sample carries an X, a Y and a Z value, each a 16-bit two's-complement fixed-point word. The block fills three holding slots in turn, then sign-extends each value to 20 bits and adds the three per axis in a two-stage pipeline. It divides each sum by the constant three in a per-axis sequential divider. One averaged triplet leaves the block, with a single-cycle valid, for every three samples it accepts, so the output rate is a third of the input rate.

A producer presents a sample with `valid_i`. The sample is taken on the clock edge at which both `valid_i` and `avail_o` are high. While a group is being summed and divided, `avail_o` stays low and the block ignores all input. The output uses the same fixed-point format as the input, because the quotient is the raw sum divided by three. The quotient is rounded toward zero.

Top module: `tri_axis_avg`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `avail_o` is 1, `avg_valid_o` is 0 and `avg_o` is all zeros.
- R2: On both buses the X axis sits in bits [15:0], Y in [31:16] and Z in [47:32], and each output axis depends only on the same axis of the inputs.
- R3: A sample is taken only on a rising edge where `valid_i` and `avail_o` are both 1. A `valid_i` pulse while `avail_o` is 0 changes neither the next result nor the grouping.
- R4: Each group of three accepted samples gives exactly one result, and each output axis equals the signed sum of the three inputs on that axis divided by 3. Example: 1, 3 and 5 give 3.
- R5: `avail_o` goes low in the cycle after the third sample of a group is accepted. It stays low until the result is presented and is 1 in the cycle in which `avg_valid_o` is 1.
- R6: `avg_valid_o` is first high in the cycle that begins 24 rising edges after the edge that took the third sample of the group.
- R7: `avg_valid_o` is high for one cycle per result, and `avg_o` keeps its value in every cycle in which `avg_valid_o` is low.
- R8: A quotient that is not exact is truncated toward zero for both signs. For example, -1, -1 and -2 give -1, and 1, 1 and 2 give 1.
- R9: Full-scale inputs do not overflow. Three samples of 32767 give 32767, three of -32768 give -32768, and the result is clamped to the 16-bit range.
- R10: Idle cycles with `valid_i` low, between or before the samples of a group, change neither the result nor the latency measured from the third accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 48 | Packed input sample: X [15:0], Y [31:16], Z [47:32] |
| valid_i | input | 1 | Input sample present |
| avail_o | output | 1 | Block can take a sample this cycle |
| avg_o | output | 48 | Averaged triplet, same packing as `sample_i` |
| avg_valid_o | output | 1 | One-cycle strobe marking a new `avg_o` |

## Verification
If the capture controller ends up in the wrong state, the first result after the fault appears at the wrong time or averages a shifted group. A bench that measures the latency of every group sees this at once, in that group. A fault in a single slot, an adder stage or a divider step leaves the timing intact, so it can only be seen in the value of one axis of the next result. A missing sign extension or a wrong rounding step shows up only for negative or non-multiple-of-three sums. For this reason the sweep mixes signs, magnitudes and full-scale values on each axis independently.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int AVG_TAPS = 3;

  typedef enum logic [2:0] {
    ST_CAP0,
    ST_CAP1,
    ST_CAP2,
    ST_LAUNCH,
    ST_WAIT
  } avg_state_e;
endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
#(
  parameter int WAIT_CYC = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  output logic                avail_o,
  output logic [AVG_TAPS-1:0] cap_o,
  output logic                start_o
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  avg_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign avail_o = (state_q == ST_CAP0) || (state_q == ST_CAP1) || (state_q == ST_CAP2);
  assign accept  = valid_i && avail_o;
  assign start_o = (state_q == ST_LAUNCH);

  always_comb begin
    cap_o    = '0;
    cap_o[0] = accept && (state_q == ST_CAP0);
    cap_o[1] = accept && (state_q == ST_CAP1);
    cap_o[2] = accept && (state_q == ST_CAP2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CAP0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_CAP0: if (accept) state_q <= ST_CAP1;
        ST_CAP1: if (accept) state_q <= ST_CAP2;
        ST_CAP2: if (accept) state_q <= ST_LAUNCH;
        ST_LAUNCH: begin
          cnt_q   <= CNT_W'(WAIT_CYC);
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          // leave on the edge that raises the output valid
          if (cnt_q == '0) state_q <= ST_CAP0;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_CAP0;
      endcase
    end
  end
endmodule

// File: rtl/avg_add_pipe.sv
module avg_add_pipe #(
  parameter int IN_W  = 16,
  parameter int EXT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  input  logic [IN_W-1:0]  c_i,
  output logic [EXT_W-1:0] sum_o
);
  localparam int PAD_W = EXT_W - IN_W;

  logic signed [EXT_W-1:0] a_x, b_x, c_x;
  logic signed [EXT_W-1:0] pair_q, c_q, sum_q;

  assign a_x = $signed({{PAD_W{a_i[IN_W-1]}}, a_i});
  assign b_x = $signed({{PAD_W{b_i[IN_W-1]}}, b_i});
  assign c_x = $signed({{PAD_W{c_i[IN_W-1]}}, c_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q <= '0;
      c_q    <= '0;
      sum_q  <= '0;
    end else begin
      pair_q <= a_x + b_x;
      c_q    <= c_x;
      sum_q  <= pair_q + c_q;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/avg_div_const.sv
module avg_div_const #(
  parameter int W       = 20,
  parameter int OUT_W   = 16,
  parameter int DIVISOR = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [W-1:0]     dividend_i,
  output logic [OUT_W-1:0] quot_o
);
  localparam int REM_W = $clog2(DIVISOR) + 1;
  localparam int CNT_W = $clog2(W);
  localparam logic signed [W:0] MAXV = (W+1)'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [W:0] MINV = -MAXV - (W+1)'(1);

  logic [W-1:0]     dvd_q, quo_q, mag;
  logic [REM_W-1:0] rem_q, rem_sh, rem_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q, busy_q, fin_q, ge;
  logic signed [W:0] sres;

  assign mag    = dividend_i[W-1] ? (~dividend_i + 1'b1) : dividend_i;
  assign rem_sh = {rem_q[REM_W-2:0], dvd_q[W-1]};
  assign ge     = rem_sh >= REM_W'(DIVISOR);
  assign rem_nx = ge ? rem_sh - REM_W'(DIVISOR) : rem_sh;
  assign sres   = neg_q ? -$signed({1'b0, quo_q}) : $signed({1'b0, quo_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      quot_o <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        dvd_q  <= mag;
        quo_q  <= '0;
        rem_q  <= '0;
        cnt_q  <= '0;
        neg_q  <= dividend_i[W-1];
        busy_q <= 1'b1;
      end else if (busy_q) begin
        dvd_q <= {dvd_q[W-2:0], 1'b0};
        quo_q <= {quo_q[W-2:0], ge};
        rem_q <= rem_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(W - 1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
      if (fin_q) begin
        if (sres > MAXV)      quot_o <= MAXV[OUT_W-1:0];
        else if (sres < MINV) quot_o <= MINV[OUT_W-1:0];
        else                  quot_o <= sres[OUT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tri_axis_avg.sv
module tri_axis_avg
  import avg_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int N_AXES   = 3,
  parameter int EXT_W    = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SAMPLE_W*N_AXES-1:0] sample_i,
  input  logic                       valid_i,
  output logic                       avail_o,
  output logic [SAMPLE_W*N_AXES-1:0] avg_o,
  output logic                       avg_valid_o
);
  localparam int BUS_W    = SAMPLE_W * N_AXES;
  localparam int ADD_LAT  = 2;
  localparam int DIV_LAT  = EXT_W + 2;
  localparam int WAIT_CYC = ADD_LAT + DIV_LAT - 2;

  logic [AVG_TAPS-1:0] cap;
  logic                start;
  logic [BUS_W-1:0]    hold_q [AVG_TAPS];
  logic [ADD_LAT-1:0]  v_add_q;
  logic [DIV_LAT-1:0]  v_div_q;
  logic [EXT_W-1:0]    sum_w [N_AXES];

  avg_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .avail_o (avail_o),
    .cap_o   (cap),
    .start_o (start)
  );

  for (genvar t = 0; t < AVG_TAPS; t++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hold_q[t] <= '0;
      else if (cap[t]) hold_q[t] <= sample_i;
    end
  end

  // valid travels beside the data through adder and divider
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_add_q <= '0;
      v_div_q <= '0;
    end else begin
      v_add_q <= {v_add_q[ADD_LAT-2:0], start};
      v_div_q <= {v_div_q[DIV_LAT-2:0], v_add_q[ADD_LAT-1]};
    end
  end

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    avg_add_pipe #(.IN_W(SAMPLE_W), .EXT_W(EXT_W)) u_add (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (hold_q[0][a*SAMPLE_W +: SAMPLE_W]),
      .b_i    (hold_q[1][a*SAMPLE_W +: SAMPLE_W]),
      .c_i    (hold_q[2][a*SAMPLE_W +: SAMPLE_W]),
      .sum_o  (sum_w[a])
    );

    avg_div_const #(.W(EXT_W), .OUT_W(SAMPLE_W), .DIVISOR(AVG_TAPS)) u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (v_add_q[ADD_LAT-1]),
      .dividend_i (sum_w[a]),
      .quot_o     (avg_o[a*SAMPLE_W +: SAMPLE_W])
    );
  end

  assign avg_valid_o = v_div_q[DIV_LAT-1];
endmodule

// File: rtl/avg_chk.sv
module avg_chk #(
  parameter int SAMPLE_W = 16,
  parameter int N_AXES   = 3,
  parameter int EXT_W    = 20
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic                       avail_o,
  input logic                       avg_valid_o,
  input logic [SAMPLE_W*N_AXES-1:0] avg_o
);
  localparam int LAT_EXP = EXT_W + 4;

  logic [1:0] acc_q;
  logic [7:0] lat_q;
  logic       accept;

  assign accept = valid_i && avail_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      lat_q <= '0;
    end else begin
      if (avg_valid_o)  acc_q <= accept ? 2'd1 : 2'd0;
      else if (accept)  acc_q <= acc_q + 2'd1;
      if (accept && acc_q == 2'd2)            lat_q <= '0;
      else if (acc_q == 2'd3 && lat_q != '1)  lat_q <= lat_q + 8'd1;
    end
  end

  // R3
  accept_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (acc_q < 2'd3 || avg_valid_o));

  // R4
  group_of_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |-> acc_q == 2'd3);

  // R5
  avail_on_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |-> avail_o);

  // R6
  fixed_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |-> lat_q == 8'(LAT_EXP));

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |=> !avg_valid_o);

  // R7
  hold_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avg_valid_o |-> $stable(avg_o));
endmodule

bind tri_axis_avg avg_chk #(.SAMPLE_W(SAMPLE_W), .N_AXES(N_AXES), .EXT_W(EXT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .avail_o     (avail_o),
  .avg_valid_o (avg_valid_o),
  .avg_o       (avg_o)
);

// File: tb/sim_tri_axis_avg.sv
`timescale 1ns/1ps
module sim_tri_axis_avg;
  localparam int SW = 16;
  localparam int NA = 3;
  localparam int LAT_NEG = 25;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [SW*NA-1:0] sample_i = '0;
  logic           valid_i = 1'b0;
  logic           avail_o;
  logic [SW*NA-1:0] avg_o;
  logic           avg_valid_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1ace_0f17;

  always #2.5 clk = ~clk;

  tri_axis_avg u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sample_i    (sample_i),
    .valid_i     (valid_i),
    .avail_o     (avail_o),
    .avg_o       (avg_o),
    .avg_valid_o (avg_valid_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int avg3(input int a, input int b, input int c);
    return (a + b + c) / 3;
  endfunction

  function automatic int axis_out(input int k);
    return int'($signed(avg_o[k*SW +: SW]));
  endfunction

  task automatic push(input int x, input int y, input int z, input int gap);
    repeat (gap) @(negedge clk);
    while (!avail_o) @(negedge clk);
    valid_i  = 1'b1;
    sample_i = {SW'(z), SW'(y), SW'(x)};
    @(negedge clk);
    valid_i  = 1'b0;
  endtask

  // s[sample][axis]
  task automatic run_group(input int s[3][3], input string req, input int gap, input bit junk);
    int n;
    bit avail_bad;
    logic [SW*NA-1:0] held;
    for (int i = 0; i < 3; i++) push(s[i][0], s[i][1], s[i][2], gap);
    n = 1;
    avail_bad = 1'b0;
    if (junk) begin
      valid_i  = 1'b1;
      sample_i = {SW'(16'h7fff), SW'(16'h8000), SW'(16'h4321)};
    end
    while (!avg_valid_o && n < 200) begin
      if (avail_o) avail_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    valid_i = 1'b0;
    check(!avail_bad, "R5", "avail low while busy", longint'(avail_bad), 0);
    check(n == LAT_NEG, "R6", "latency", n, LAT_NEG);
    check(avail_o == 1'b1, "R5", "avail with result", avail_o, 1);
    for (int k = 0; k < NA; k++) begin
      int e;
      e = avg3(s[0][k], s[1][k], s[2][k]);
      check(axis_out(k) == e, req, $sformatf("axis %0d value", k), axis_out(k), e);
    end
    held = avg_o;
    @(negedge clk);
    check(avg_valid_o == 1'b0, "R7", "valid one cycle", avg_valid_o, 0);
    check(avg_o == held, "R7", "output held", avg_o, held);
  endtask

  function automatic int next_val();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s[3][3];
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(avail_o == 1'b1, "R1", "avail in reset", avail_o, 1);
    check(avg_valid_o == 1'b0, "R1", "valid in reset", avg_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(avail_o == 1'b1, "R1", "avail after reset", avail_o, 1);
    check(avg_valid_o == 1'b0, "R1", "valid after reset", avg_valid_o, 0);
    check(avg_o == '0, "R1", "output after reset", avg_o, 0);

    // R4 worked example on X
    s = '{'{1, 10, -7}, '{3, 20, -7}, '{5, 30, -7}};
    run_group(s, "R4", 0, 1'b0);
    // R2 distinct per-axis magnitudes
    s = '{'{100, -2000, 30000}, '{200, -4000, 30001}, '{300, -6000, 30002}};
    run_group(s, "R2", 0, 1'b0);
    // R8 truncation toward zero
    s = '{'{-1, 1, -2}, '{-1, 1, -2}, '{-2, 2, -1}};
    run_group(s, "R8", 0, 1'b0);
    s = '{'{-5, 5, -32768}, '{0, 0, 0}, '{0, 0, 1}};
    run_group(s, "R8", 0, 1'b0);
    // R9 full scale
    s = '{'{32767, -32768, 32767}, '{32767, -32768, 32767}, '{32767, -32768, 32766}};
    run_group(s, "R9", 0, 1'b0);
    s = '{'{-32768, 32767, -32768}, '{-32768, 32767, -32768}, '{-32767, 32767, -32768}};
    run_group(s, "R9", 0, 1'b0);
    // R10 idle gaps between samples
    s = '{'{7, -8, 9}, '{70, -80, 90}, '{700, -800, 900}};
    run_group(s, "R10", 3, 1'b0);
    // R3 valid while busy must be ignored
    s = '{'{11, 12, 13}, '{-11, -12, -13}, '{4, 4, 4}};
    run_group(s, "R3", 0, 1'b1);
    s = '{'{6, 6, 6}, '{9, 9, 9}, '{-3, 0, 3}};
    run_group(s, "R3", 1, 1'b1);

    // R4 pseudo-random sweep, mixed signs
    for (int g = 0; g < 40; g++) begin
      for (int i = 0; i < 3; i++)
        for (int k = 0; k < 3; k++) s[i][k] = next_val();
      run_group(s, "R4", g % 3, g[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule